// File: doc/BRIEF.md
# Low-Power Mode Sequencer With Snoop Handshake

This block is the power-state controller of a processor core. Software sets a three-bit mode selection and a power-enable bit; the sequencer then moves the core into a doze, nap or sleep state and drives the enables that gate the core's functional-unit clocks, its input receivers, its bus snooping and its timer clocks. Doze is entered at once. Nap and sleep first run a quiesce handshake with the system: the block raises a quiesce request, waits for the system's acknowledge, and then spends a fixed number of core clocks before it settles in the low-power state.

While the core naps or sleeps, the system can ask for one snoop by dropping the acknowledge for a minimum number of bus clocks. The block then opens a snoop window with receivers and snooping enabled. Once a snoop has completed and the acknowledge is back, it returns to the low-power state it came from. Any wake event (external interrupt, system-management interrupt, machine check, decrementer, performance monitor, thermal event or soft reset) returns the core to full power on the next clock, and a hard reset does the same asynchronously. An output for external cache SRAM asks for its low-power mode while the core naps or sleeps, if software has enabled that output.

Top module: `pwr_mode_seq`

## Requirements
- R1: After hard reset the state is FULL. The state one-hot output uses bit 0 FULL, 1 DOZE, 2 QUIESCE_WAIT, 3 ENTER_DELAY, 4 NAP, 5 SLEEP, 6 SNOOP_WINDOW. In FULL, quiesce_req and ext_sram_sleep are 0 and every enable output is 1.
- R2: In FULL, with pow_en=1 and mode_sel=3'b001 (bit 0 doze, bit 1 nap, bit 2 sleep), the block enters DOZE on the next clock without raising quiesce_req.
- R3: In FULL, with pow_en=1 and mode_sel equal to 3'b010 (nap) or 3'b100 (sleep), the block enters QUIESCE_WAIT on the next clock and quiesce_req is 1.
- R4: With pow_en=0, or with mode_sel 3'b000 or any value that has more than one bit set, the block stays in FULL.
- R5: QUIESCE_WAIT stays until quiesce_ack is sampled 1. The block then spends exactly ENTER_CYC clocks (default 6) in ENTER_DELAY before it enters NAP or SLEEP, whichever was requested.
- R6: A 1 on any wake_evt bit (0 external interrupt, 1 system-management interrupt, 2 machine check, 3 decrementer, 4 performance monitor, 5 thermal) or on soft_rst moves any state other than FULL to FULL on the next clock, and quiesce_req drops with it. This includes aborting QUIESCE_WAIT and ENTER_DELAY. In FULL a wake event blocks entry.
- R7: A saturating counter counts bus clocks (cycles with bus_tick=1) while quiesce_ack=0 and is cleared by every cycle with quiesce_ack=1. In NAP or SLEEP, once the counter has reached ACK_LOW_MIN (default 4), the block enters SNOOP_WINDOW on the next clock. Fewer ticks followed by quiesce_ack=1 leave it in place.
- R8: SNOOP_WINDOW returns to the low-power state it came from in the cycle after quiesce_ack=1 is sampled, provided a snoop_done pulse has been seen in the window or is present in that cycle. Without snoop_done the window stays open.
- R9: ext_sram_sleep is 1 exactly when the state is NAP or SLEEP and cache_lp_en=1.
- R10: unit_clk_en is 1 only in FULL, QUIESCE_WAIT and ENTER_DELAY. rcv_en is 0 only in NAP and SLEEP. snoop_en is 0 only in ENTER_DELAY, NAP and SLEEP. timer_clk_en is 0 only in SLEEP. quiesce_req is 1 in QUIESCE_WAIT, ENTER_DELAY, NAP, SLEEP and SNOOP_WINDOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft-reset wake event |
| wake_evt | input | NUM_WAKE (6) | Wake event sources, one per bit |
| mode_sel | input | 3 | Mode bits: bit 0 doze, bit 1 nap, bit 2 sleep |
| pow_en | input | 1 | Power-saving enable |
| cache_lp_en | input | 1 | Enables the external SRAM low-power output |
| quiesce_ack | input | 1 | Quiesce acknowledge from the system |
| bus_tick | input | 1 | One-cycle strobe per bus clock |
| snoop_done | input | 1 | Pulse: the serviced snoop has completed |
| quiesce_req | output | 1 | Quiesce request to the system |
| state_oh | output | 7 | One-hot current state |
| unit_clk_en | output | 1 | Functional-unit clock enable |
| rcv_en | output | 1 | Nonessential input receiver enable |
| snoop_en | output | 1 | Bus snoop enable |
| timer_clk_en | output | 1 | Time base, decrementer, thermal and monitor clock enable |
| ext_sram_sleep | output | 1 | External cache SRAM low-power request |

## Verification
The bench tests the acknowledge filter at its edge. Exactly three bus ticks of low acknowledge followed by a high one must not open a window; a design that failed to clear the counter, or that counted core clocks in place of bus ticks, would drop into SNOOP_WINDOW too early. It raises the acknowledge before any snoop completes, and also completes a snoop before the acknowledge returns. A design that ignored snoop_done would close the window too soon, and one that did not remember it would hang in the window. Each wake source and soft reset is applied in turn, including aborts from QUIESCE_WAIT and ENTER_DELAY, where a design that finished the entry would leave quiesce_req high. Invalid mode combinations, and the ENTER_DELAY length counted in clocks, are also checked.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    ST_FULL  = 3'd0,
    ST_DOZE  = 3'd1,
    ST_QWAIT = 3'd2,
    ST_ENTER = 3'd3,
    ST_NAP   = 3'd4,
    ST_SLEEP = 3'd5,
    ST_SNOOP = 3'd6
  } pms_state_e;

  localparam int NUM_STATES = 7;
  localparam int MODE_W     = 3;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_DOZE  = 2'd1,
    REQ_NAP   = 2'd2,
    REQ_SLEEP = 2'd3
  } pms_req_e;

  // Exactly one mode bit together with the enable forms a valid request.
  function automatic pms_req_e decode_mode(logic [MODE_W-1:0] bits, logic pow);
    pms_req_e r;
    r = REQ_NONE;
    if (pow) begin
      unique case (bits)
        3'b001:  r = REQ_DOZE;
        3'b010:  r = REQ_NAP;
        3'b100:  r = REQ_SLEEP;
        default: r = REQ_NONE;
      endcase
    end
    return r;
  endfunction

  function automatic logic is_lowpower(pms_state_e s);
    return (s == ST_NAP) || (s == ST_SLEEP);
  endfunction

endpackage

// File: rtl/pms_req_decode.sv
module pms_req_decode
  import pms_pkg::*;
#(
  parameter int NUM_WAKE = 6
) (
  input  logic [MODE_W-1:0]   mode_sel,
  input  logic                pow_en,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic                soft_rst,
  output pms_req_e            req,
  output logic                wake
);

  assign req  = decode_mode(mode_sel, pow_en);
  assign wake = (|wake_evt) | soft_rst;

  always_comb begin
    if (req != REQ_NONE) begin
      assert ($countones(mode_sel) == 1 && pow_en)
        else $error("p_single_mode_r4: request decoded from invalid mode bits");
    end
  end

endmodule

// File: rtl/pms_ack_filter.sv
module pms_ack_filter #(
  parameter int ACK_LOW_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic quiesce_ack,
  input  logic bus_tick,
  output logic ack_low_met
);

  localparam int CW = $clog2(ACK_LOW_MIN + 1);
  localparam logic [CW-1:0] SAT = CW'(ACK_LOW_MIN);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (quiesce_ack) low_cnt <= '0;
    else if (bus_tick && (low_cnt != SAT)) low_cnt <= low_cnt + 1'b1;
  end

  assign ack_low_met = (low_cnt == SAT);

  p_sat_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= SAT);
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    quiesce_ack |=> !ack_low_met);
  p_no_tick_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiesce_ack && !bus_tick) |=> $stable(low_cnt));

endmodule

// File: rtl/pms_enter_timer.sv
module pms_enter_timer #(
  parameter int ENTER_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(ENTER_CYC + 1);
  localparam logic [CW-1:0] START = CW'(ENTER_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= START;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);

  p_load_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == START);
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pms_req_e   req,
  input  logic       wake,
  input  logic       quiesce_ack,
  input  logic       ack_low_met,
  input  logic       delay_done,
  input  logic       snoop_done,
  output pms_state_e state,
  output logic       timer_load,
  output logic       timer_run
);

  pms_state_e state_nx;
  logic       tgt_sleep, tgt_sleep_nx;
  logic       snoop_seen;
  pms_state_e lp_target;

  assign lp_target  = tgt_sleep ? ST_SLEEP : ST_NAP;
  assign timer_load = (state == ST_QWAIT) && quiesce_ack;
  assign timer_run  = (state == ST_ENTER);

  always_comb begin
    state_nx     = state;
    tgt_sleep_nx = tgt_sleep;
    unique case (state)
      ST_FULL: begin
        if (!wake) begin
          unique case (req)
            REQ_DOZE:  state_nx = ST_DOZE;
            REQ_NAP:   begin state_nx = ST_QWAIT; tgt_sleep_nx = 1'b0; end
            REQ_SLEEP: begin state_nx = ST_QWAIT; tgt_sleep_nx = 1'b1; end
            default:   state_nx = ST_FULL;
          endcase
        end
      end
      ST_DOZE:  state_nx = ST_DOZE;
      ST_QWAIT: if (quiesce_ack) state_nx = ST_ENTER;
      ST_ENTER: if (delay_done) state_nx = lp_target;
      ST_NAP, ST_SLEEP: if (ack_low_met) state_nx = ST_SNOOP;
      ST_SNOOP: if (quiesce_ack && (snoop_seen || snoop_done)) state_nx = lp_target;
      default:  state_nx = ST_FULL;
    endcase
    if (wake && state != ST_FULL) state_nx = ST_FULL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_FULL;
      tgt_sleep  <= 1'b0;
      snoop_seen <= 1'b0;
    end else begin
      state      <= state_nx;
      tgt_sleep  <= tgt_sleep_nx;
      snoop_seen <= (state == ST_SNOOP) && (snoop_seen || snoop_done);
    end
  end

  p_wake_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && state != ST_FULL) |=> state == ST_FULL);
  p_hold_for_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_QWAIT && !quiesce_ack && !wake) |=> state == ST_QWAIT);
  p_snoop_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SNOOP && !snoop_seen && !snoop_done && !wake) |=> state == ST_SNOOP);
  p_doze_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FULL && req == REQ_DOZE && !wake) |=> state == ST_DOZE);
  p_invalid_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FULL && req == REQ_NONE) |=> state == ST_FULL);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int NUM_WAKE    = 6,
  parameter int ENTER_CYC   = 6,
  parameter int ACK_LOW_MIN = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic [NUM_WAKE-1:0]   wake_evt,
  input  logic [2:0]            mode_sel,
  input  logic                  pow_en,
  input  logic                  cache_lp_en,
  input  logic                  quiesce_ack,
  input  logic                  bus_tick,
  input  logic                  snoop_done,
  output logic                  quiesce_req,
  output logic [NUM_STATES-1:0] state_oh,
  output logic                  unit_clk_en,
  output logic                  rcv_en,
  output logic                  snoop_en,
  output logic                  timer_clk_en,
  output logic                  ext_sram_sleep
);

  pms_req_e   req;
  logic       wake;
  logic       ack_low_met;
  logic       delay_done;
  logic       timer_load;
  logic       timer_run;
  pms_state_e state;

  pms_req_decode #(.NUM_WAKE(NUM_WAKE)) u_dec (
    .mode_sel (mode_sel),
    .pow_en   (pow_en),
    .wake_evt (wake_evt),
    .soft_rst (soft_rst),
    .req      (req),
    .wake     (wake)
  );

  pms_ack_filter #(.ACK_LOW_MIN(ACK_LOW_MIN)) u_filt (
    .clk         (clk),
    .rst_n       (rst_n),
    .quiesce_ack (quiesce_ack),
    .bus_tick    (bus_tick),
    .ack_low_met (ack_low_met)
  );

  pms_enter_timer #(.ENTER_CYC(ENTER_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .run     (timer_run),
    .expired (delay_done)
  );

  pms_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .wake        (wake),
    .quiesce_ack (quiesce_ack),
    .ack_low_met (ack_low_met),
    .delay_done  (delay_done),
    .snoop_done  (snoop_done),
    .state       (state),
    .timer_load  (timer_load),
    .timer_run   (timer_run)
  );

  for (genvar i = 0; i < NUM_STATES; i++) begin : g_oh
    assign state_oh[i] = (state == pms_state_e'(i));
  end

  logic in_lp;
  assign in_lp          = is_lowpower(state);
  assign quiesce_req    = !(state_oh[ST_FULL] || state_oh[ST_DOZE]);
  assign unit_clk_en    = state_oh[ST_FULL] || state_oh[ST_QWAIT] || state_oh[ST_ENTER];
  assign rcv_en         = !in_lp;
  assign snoop_en       = !(in_lp || state_oh[ST_ENTER]);
  assign timer_clk_en   = !state_oh[ST_SLEEP];
  assign ext_sram_sleep = cache_lp_en && in_lp;

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1);
  p_sram_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sram_sleep |-> (quiesce_req && !unit_clk_en && !rcv_en));
  p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(quiesce_req) |-> state_oh[ST_FULL]);
  p_snoop_rcv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_en |-> rcv_en);

endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;

  localparam int NW = 6;
  localparam int EC = 6;
  localparam int AL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [NW-1:0] wake_evt = '0;
  logic [2:0] mode_sel = 3'b000;
  logic pow_en = 1'b0, cache_lp_en = 1'b0, quiesce_ack = 1'b0;
  logic bus_tick = 1'b0, snoop_done = 1'b0;
  logic quiesce_req, unit_clk_en, rcv_en, snoop_en, timer_clk_en, ext_sram_sleep;
  logic [6:0] state_oh;

  always #10 clk = ~clk;

  pwr_mode_seq #(.NUM_WAKE(NW), .ENTER_CYC(EC), .ACK_LOW_MIN(AL)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wake_evt(wake_evt),
    .mode_sel(mode_sel), .pow_en(pow_en), .cache_lp_en(cache_lp_en),
    .quiesce_ack(quiesce_ack), .bus_tick(bus_tick), .snoop_done(snoop_done),
    .quiesce_req(quiesce_req), .state_oh(state_oh), .unit_clk_en(unit_clk_en),
    .rcv_en(rcv_en), .snoop_en(snoop_en), .timer_clk_en(timer_clk_en),
    .ext_sram_sleep(ext_sram_sleep));

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit running = 1'b0;

  // Behavioural model: 0 full,1 doze,2 qwait,3 enter,4 nap,5 sleep,6 snoop
  int ms = 0, mlo = 0, mdel = 0;
  bit mtgt_sleep = 1'b0, mseen = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mlo = 0; mdel = 0; mtgt_sleep = 1'b0; mseen = 1'b0;
    end else begin
      bit w; int rq; int ns; int nlo; int ndel; bit nseen; bit ntgt;
      w = (wake_evt != 0) || soft_rst;
      rq = 0;
      if (pow_en && mode_sel == 3'b001) rq = 1;
      if (pow_en && mode_sel == 3'b010) rq = 2;
      if (pow_en && mode_sel == 3'b100) rq = 3;
      ns = ms; ntgt = mtgt_sleep; ndel = mdel;
      if (ms == 0 && !w) begin
        if (rq == 1) ns = 1;
        if (rq == 2) begin ns = 2; ntgt = 1'b0; end
        if (rq == 3) begin ns = 2; ntgt = 1'b1; end
      end
      if (ms == 2 && quiesce_ack) begin ns = 3; ndel = EC - 1; end
      if (ms == 3) begin
        if (mdel == 0) ns = mtgt_sleep ? 5 : 4;
        else ndel = mdel - 1;
      end
      if ((ms == 4 || ms == 5) && mlo >= AL) ns = 6;
      if (ms == 6 && quiesce_ack && (mseen || snoop_done)) ns = mtgt_sleep ? 5 : 4;
      if (w && ms != 0) ns = 0;
      nlo = quiesce_ack ? 0 : ((bus_tick && mlo < AL) ? mlo + 1 : mlo);
      nseen = (ms == 6) && (mseen || snoop_done);
      ms = ns; mlo = nlo; mdel = ndel; mtgt_sleep = ntgt; mseen = nseen;
    end
  end

  function automatic logic [12:0] model_out();
    logic [6:0] oh;
    bit lp;
    oh = 7'd1 << ms;
    lp = (ms == 4 || ms == 5);
    return {oh, (ms >= 2), (ms == 0 || ms == 2 || ms == 3), !lp,
            !(lp || ms == 3), (ms != 5), (cache_lp_en && lp)};
  endfunction

  always @(negedge clk) begin
    if (running) begin
      logic [12:0] act, exp_v;
      act = {state_oh, quiesce_req, unit_clk_en, rcv_en, snoop_en, timer_clk_en, ext_sram_sleep};
      exp_v = model_out();
      n_cmp++;
      if (act !== exp_v) begin
        n_bad++;
        $display("FAIL %s cycle compare: actual %b expected %b", cur_req, act, exp_v);
      end
    end
  end

  task automatic check(string req, string what, logic [6:0] act, logic [6:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp_v);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  always begin
    @(negedge clk); #1;
    bus_tick = ~bus_tick;
  end

  task automatic go_full(string req);
    pow_en = 1'b0; mode_sel = 3'b000;
    wake_evt = 6'b000001; step(1);
    wake_evt = '0;
    check(req, "back to FULL", state_oh, 7'b0000001);
    check(req, "quiesce_req dropped", {6'b0, quiesce_req}, 7'd0);
  endtask

  task automatic enter_lp(bit sleep_md, string req);
    quiesce_ack = 1'b0;
    mode_sel = sleep_md ? 3'b100 : 3'b010; pow_en = 1'b1;
    step(1);
    pow_en = 1'b0; mode_sel = 3'b000;
    check("R3", "qwait state", state_oh, 7'b0000100);
    step(3);
    check("R5", "holds without ack", state_oh, 7'b0000100);
    quiesce_ack = 1'b1; step(1);
    check("R5", "enter delay", state_oh, 7'b0001000);
    step(EC - 1);
    check("R5", "still in delay at last cycle", state_oh, 7'b0001000);
    step(1);
    check(req, "low-power state", state_oh, sleep_md ? 7'b0100000 : 7'b0010000);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    running = 1'b1;
    step(1);
    cur_req = "R1";
    check("R1", "reset state", state_oh, 7'b0000001);
    check("R1", "reset enables", {1'b0, quiesce_req, unit_clk_en, rcv_en, snoop_en, timer_clk_en, ext_sram_sleep},
          7'b0011110);

    cur_req = "R4";
    pow_en = 1'b0; mode_sel = 3'b010; step(3);
    check("R4", "no enable", state_oh, 7'b0000001);
    pow_en = 1'b1;
    mode_sel = 3'b011; step(2);
    mode_sel = 3'b110; step(2);
    mode_sel = 3'b111; step(2);
    mode_sel = 3'b000; step(2);
    check("R4", "invalid combos", state_oh, 7'b0000001);
    mode_sel = 3'b010; wake_evt = 6'b001000; step(1);
    check("R4", "wake blocks entry", state_oh, 7'b0000001);
    wake_evt = '0; pow_en = 1'b0; mode_sel = 3'b000; step(1);

    cur_req = "R2";
    for (int i = 0; i < NW + 1; i++) begin
      mode_sel = 3'b001; pow_en = 1'b1; step(1);
      pow_en = 1'b0; mode_sel = 3'b000;
      check("R2", "doze entered", state_oh, 7'b0000010);
      check("R2", "no quiesce in doze", {5'b0, quiesce_req, unit_clk_en}, 7'd0);
      step(2);
      cur_req = "R6";
      if (i < NW) wake_evt = NW'(1) << i; else soft_rst = 1'b1;
      step(1);
      wake_evt = '0; soft_rst = 1'b0;
      check("R6", "wake source exits doze", state_oh, 7'b0000001);
      cur_req = "R2";
    end

    cur_req = "R7";
    cache_lp_en = 1'b1;
    enter_lp(1'b0, "R5");
    check("R9", "sram sleep with enable", {6'b0, ext_sram_sleep}, 7'd1);
    check("R10", "nap enables", {2'b0, unit_clk_en, rcv_en, snoop_en, timer_clk_en, quiesce_req}, 7'b0000011);
    quiesce_ack = 1'b0; step(6);
    quiesce_ack = 1'b1; step(2);
    check("R7", "three ticks insufficient", state_oh, 7'b0010000);
    quiesce_ack = 1'b0; step(12);
    check("R7", "snoop window opened", state_oh, 7'b1000000);
    cur_req = "R8";
    check("R8", "window enables", {4'b0, rcv_en, snoop_en, ext_sram_sleep}, 7'b0000110);
    quiesce_ack = 1'b1; step(4);
    check("R8", "no snoop done keeps window", state_oh, 7'b1000000);
    snoop_done = 1'b1; step(1); snoop_done = 1'b0;
    check("R8", "returns to nap", state_oh, 7'b0010000);
    cur_req = "R6";
    go_full("R6");

    cur_req = "R9";
    cache_lp_en = 1'b0;
    enter_lp(1'b1, "R5");
    check("R9", "no sram sleep without enable", {6'b0, ext_sram_sleep}, 7'd0);
    check("R10", "sleep timer gated", {6'b0, timer_clk_en}, 7'd0);
    cur_req = "R8";
    quiesce_ack = 1'b0; step(10);
    check("R7", "sleep snoop window", state_oh, 7'b1000000);
    snoop_done = 1'b1; step(1); snoop_done = 1'b0; step(3);
    check("R8", "waits for ack after done", state_oh, 7'b1000000);
    quiesce_ack = 1'b1; step(1);
    check("R8", "returns to sleep", state_oh, 7'b0100000);
    cur_req = "R6";
    wake_evt = 6'b100000; step(1); wake_evt = '0;
    check("R6", "thermal wakes sleep", state_oh, 7'b0000001);

    cur_req = "R6";
    quiesce_ack = 1'b0; mode_sel = 3'b100; pow_en = 1'b1; step(1);
    pow_en = 1'b0; mode_sel = 3'b000; step(2);
    wake_evt = 6'b000010; step(1); wake_evt = '0;
    check("R6", "abort qwait", state_oh, 7'b0000001);
    mode_sel = 3'b010; pow_en = 1'b1; step(1);
    pow_en = 1'b0; mode_sel = 3'b000;
    quiesce_ack = 1'b1; step(3);
    check("R6", "in delay before abort", state_oh, 7'b0001000);
    soft_rst = 1'b1; step(1); soft_rst = 1'b0;
    check("R6", "abort delay", state_oh, 7'b0000001);
    check("R6", "quiesce_req low after abort", {6'b0, quiesce_req}, 7'd0);
    step(4);

    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule